// File: doc/BRIEF.md
# Cache-Miss Stall Cycle Accumulator

This block counts the clock cycles in which a processor is held off by instruction-cache misses. The count serves as a profiling aid when tuning code for speed. Software reaches it through two byte-wide registers on a simple strobe bus. The upper register shows the top seven count bits together with a sticky wrap flag. The lower register shows four middle count bits. Those bits are frozen into it at the moment the upper register is read, so that a pair of reads gives one consistent value.

The least-significant count bit is never visible. Software therefore recovers the stall total as twice the concatenation of the two visible fields, rounded down to an even number. Writing the upper register presets the top bits, zeroes the five bits below them and clears the wrap flag. A write and a read each take one cycle with the strobe high. Read data is combinational from the address.

Top module: `stall_acc`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), the upper register (`addr_i`=0) reads 0x00 and the lower register (`addr_i`=1) reads 0x00.
- R2: The 12-bit count rises by exactly one at each clock edge where `stall_i` is high and no upper-register write occurs. It holds its value when `stall_i` is low.
- R3: The wrap flag sits in bit 7 of the upper register. It is set at the edge where the count steps from 0xFFF to 0x000. It then stays set through any further counting or wraps, until the upper register is written.
- R4: A write to the upper register (`wr_i`=1, `addr_i`=0) puts `wdata_i[6:0]` into count bits 11:5, zeroes count bits 4:0 and clears the wrap flag.
- R5: When an upper-register write and a stall fall in the same cycle, the write wins and that cycle's increment is lost.
- R6: Reading the upper register (`rd_i`=1, `addr_i`=0) returns {wrap flag, count[11:5]}. At the closing edge of the same access, count[4:1] is copied into the snapshot.
- R7: The lower register reads {3'b000, snapshot[3:0], 1'b0}. It changes only on an upper-register read, not on counting.
- R8: If a stall increment shares the cycle of an upper-register read, both the returned upper bits and the snapshot carry the value before the increment.
- R9: Writes to the lower-register address have no effect on either register.
- R10: After N stall cycles counted from a cleared count, 2 × {upper[6:0], lower[4:1]} equals N rounded down to an even number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Processor held off by a cache miss this cycle |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 upper, 1 lower |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |

## Verification
Read data is combinational, so the value returned by a read is due in the same cycle as the strobe. The bench samples it a short delay after driving the strobe on the falling edge, before the rising edge. A stall, a write or a snapshot capture takes effect at the next rising edge. Every check of that effect is made through a later read, issued on a following falling edge once the edge has passed. The same-cycle cases (read with increment, write with increment) sample the read value before the edge and the snapshot afterwards.

// File: rtl/stall_acc.sv
module stall_acc #(
  parameter int CNT_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int HI_W    = DATA_W - 1;
  localparam int LO_SPAN = CNT_W - HI_W;
  localparam int SNAP_W  = LO_SPAN - 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]  cnt;
  logic              ovf;
  logic [SNAP_W-1:0] snap;
  logic              unused_wbit;

  wire hi_wr = wr_i & ~addr_i;
  wire hi_rd = rd_i & ~addr_i;

  assign unused_wbit = wdata_i[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (hi_wr) begin
      cnt <= {wdata_i[HI_W-1:0], {LO_SPAN{1'b0}}};
      ovf <= 1'b0;
    end else if (stall_i) begin
      cnt <= cnt + ONE;
      if (&cnt) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        snap <= '0;
    else if (hi_rd) snap <= cnt[LO_SPAN-1:1];
  end

  assign rdata_o = addr_i ? DATA_W'({snap, 1'b0})
                          : {ovf, cnt[CNT_W-1:LO_SPAN]};

  // R2: one step per stall cycle, hold otherwise
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !hi_wr) |=> cnt == $past(cnt) + ONE);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !hi_wr) |=> $stable(cnt));
  // R3: set on wrap, sticky until written
  a_r3_set: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !hi_wr && (&cnt)) |=> ovf);
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !hi_wr) |=> ovf);
  // R4/R5: write clears low bits and flag, beating a stall
  a_r4_write: assert property (@(posedge clk) disable iff (rst)
    hi_wr |=> (cnt[LO_SPAN-1:0] == '0) && !ovf);
  // R6/R8: snapshot takes the pre-edge count
  a_r6_snap: assert property (@(posedge clk) disable iff (rst)
    hi_rd |=> snap == $past(cnt[LO_SPAN-1:1]));
  // R7: snapshot still otherwise
  a_r7_snap_hold: assert property (@(posedge clk) disable iff (rst)
    !hi_rd |=> $stable(snap));
endmodule

// File: tb/sim_stall_acc.sv
module sim_stall_acc;
  logic clk = 0, rst = 1, stall_i = 0, rd_i = 0, wr_i = 0, addr_i = 0;
  logic [7:0] wdata_i = 0;
  logic [7:0] rdata_o;
  int total = 0, fails = 0;

  stall_acc u0 (.clk(clk), .rst(rst), .stall_i(stall_i), .rd_i(rd_i), .wr_i(wr_i),
                .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic a, input logic st, output logic [7:0] v);
    @(negedge clk); rd_i = 1; addr_i = a; stall_i = st;
    #2 v = rdata_o;
    @(negedge clk); rd_i = 0; stall_i = 0; addr_i = 0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input logic st);
    @(negedge clk); wr_i = 1; addr_i = a; wdata_i = d; stall_i = st;
    @(negedge clk); wr_i = 0; stall_i = 0; addr_i = 0;
  endtask

  task automatic stall(input int n);
    @(negedge clk); stall_i = 1;
    repeat (n) @(negedge clk);
    stall_i = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(1, 0, v); chk("R1 lower", v, 8'h00);
    rd(0, 0, v); chk("R1 upper", v, 8'h00);
  endtask

  task automatic t_count;
    logic [7:0] h, l;
    stall(20); repeat (5) @(negedge clk); stall(17);   // 37 = 0x025
    rd(0, 0, h); chk("R2/R6 upper", h, 8'h01);
    rd(1, 0, l); chk("R7 lower", l, 8'h04);
    chk("R10 total", 8'(2 * {h[6:0], l[4:1]}), 8'd36);
    stall(3);                                         // 40, snapshot unchanged
    rd(1, 0, l); chk("R7 no change on count", l, 8'h04);
  endtask

  task automatic t_write;
    logic [7:0] v;
    stall(9);
    wr(0, 8'hD5, 0);                                  // 0x55 -> bits 11:5
    rd(0, 0, v); chk("R4 upper", v, 8'h55);
    rd(1, 0, v); chk("R4 low bits cleared", v, 8'h00);
  endtask

  task automatic t_wr_stall;
    logic [7:0] v;
    wr(0, 8'h10, 1);
    rd(0, 0, v); chk("R5 upper", v, 8'h10);
    rd(1, 0, v); chk("R5 increment dropped", v, 8'h00);
  endtask

  task automatic t_overflow;
    logic [7:0] v;
    wr(0, 8'h7F, 0);                                  // 0xFE0
    stall(31);                                        // 0xFFF
    rd(0, 0, v); chk("R3 no flag before wrap", v, 8'h7F);
    stall(1);                                         // wraps to 0
    rd(0, 0, v); chk("R3 flag on wrap", v, 8'h80);
    stall(4096 + 10);                                 // second wrap, then 10
    rd(0, 0, v); chk("R3 sticky", v, 8'h80);
    rd(1, 0, v); chk("R3 low after wraps", v, 8'h0A);
    wr(0, 8'h00, 0);
    rd(0, 0, v); chk("R3/R4 write clears flag", v, 8'h00);
  endtask

  task automatic t_rd_inc;
    logic [7:0] v;
    wr(0, 8'h00, 0);
    stall(3);                                         // 3
    rd(0, 1, v); chk("R8 upper pre-increment", v, 8'h00);
    rd(1, 0, v); chk("R8 snapshot pre-increment", v, 8'h02);
    rd(0, 0, v);                                      // now 4
    rd(1, 0, v); chk("R6 fresh snapshot", v, 8'h04);
  endtask

  task automatic t_lo_write;
    logic [7:0] v;
    wr(1, 8'hFF, 0);
    rd(1, 0, v); chk("R9 lower unchanged", v, 8'h04);
    rd(0, 0, v); chk("R9 upper unchanged", v, 8'h00);
  endtask

  initial begin
    #(200000 * 8);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_count();
    t_write();
    t_wr_stall();
    t_overflow();
    t_rd_inc();
    t_lo_write();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule